// File: doc/BRIEF.md
# Serial ADC Interface Front End

This block is the digital half of an eight-input, 12-bit successive-approximation converter with a four-wire serial port. The port has an active-low chip select, a serial clock driven by the host, serial data in and serial data out. A strobe output marks the start of each result. The host clocks in a control byte after chip select falls. The byte begins at the first 1 on the data line, and any zeros before it are discarded. The byte chooses the input channel, the input pairing, the output coding and the clock mode. The block raises a track window while the last three control bits arrive. It closes the window into a hold instant, and at that instant it latches the 12-bit code from an analog stand-in input. It then shifts the result out MSB first, framed inside a 24-clock transfer.

All serial pins pass through a synchronizer into the system clock domain. Every action is tied to a detected serial-clock edge. Only the external-clock conversion mode produces a result. Any other clock-mode code is decoded and then parked until chip select rises. Raising chip select at any point abandons the transfer and rearms start-bit detection.

Top module: `adc_serial_fe`

## Requirements
- R1: While chip select is high, serial clock edges and data are ignored: the control register, track, busy, strobe and data out do not change.
- R2: With chip select low, data is taken on rising serial clock edges. Zeros before the first 1 are discarded. That 1 and the next seven bits form the control byte, MSB first, and the byte appears on `ctrl_o` after the eighth bit. The fields are: bit 7 start, bits 6:4 select, bit 3 unipolar (1) or bipolar (0), bit 2 single-ended (1) or differential (0), bits 1:0 clock mode.
- R3: Channel decode: positive channel = {sel[5:4], sel[6]} of the control byte. Single-ended sets `neg_com_o`=1 and `ch_neg_o`=0. Differential sets `neg_com_o`=0 and `ch_neg_o` = positive channel XOR 1. `bipolar_o` = NOT bit 3.
- R4: Counting the start bit as control bit 1, `track_o` rises on the falling edge after bit 5 and drops on the falling edge after bit 8. In external-clock mode, `busy_o` rises on that same falling edge after bit 8 and drops on the 21st falling edge.
- R5: In external-clock mode, `strb_o` is high from the 8th falling edge to the 9th falling edge, and low at all other times.
- R6: Data out changes only on falling edges or when chip select rises. Falling edges 9 to 20 present result bits 11 down to 0. At all other times data out is 0, so the bits read on rising edges 9 to 24 form {0, result, 000}.
- R7: The sample input is latched on the 8th falling edge, and later changes do not affect the result being shifted out.
- R8: Unipolar results equal the sample code; bipolar results equal the sample code XOR 0x800 (two's complement).
- R9: Clock mode 11 selects external-clock conversion. Any other mode gives no strobe, no busy and a zero data out, and bits are ignored until chip select rises.
- R10: Raising chip select at any time clears track, busy, strobe and data out. It keeps the last complete control byte and rearms start-bit detection.
- R11: After the 21st falling edge, start-bit detection rearms without a chip select toggle. Ones on data in during the result phase are ignored.
- R12: After reset all outputs are 0 except `bipolar_o`=1 and `ch_neg_o`=1, which are the decode of a zero control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from host |
| din_i | input | 1 | Serial data in |
| sample_i | input | DATA_W | Converter code, straight binary |
| dout_o | output | 1 | Serial data out |
| strb_o | output | 1 | Result strobe |
| track_o | output | 1 | Track window |
| busy_o | output | 1 | Hold and conversion phase |
| ctrl_o | output | 8 | Last complete control byte |
| ch_pos_o | output | 3 | Positive input channel |
| ch_neg_o | output | 3 | Negative input channel (differential) |
| neg_com_o | output | 1 | Negative input is common |
| bipolar_o | output | 1 | Two's complement coding |

## Verification
The hardest states to reach are the ones where the serial protocol is cut short or run back-to-back. Examples are chip select rising halfway through the result, a parked non-external byte followed by more traffic, and a second control byte that follows the 21st falling edge with chip select still low. The bench uses a frame task that sets the leading-zero count, the fill level of the data line during the result phase, the clock count, and whether chip select stays low at the end. This lets single calls leave the block in those states before the next frame is checked. The sample input is also changed mid-shift, so a late latch would show up in the received word.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_CTRL, ST_CONV, ST_PARK} seq_st_e;

  typedef struct packed {
    logic       start;
    logic [2:0] sel;
    logic       unipolar;
    logic       single;
    logic [1:0] mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int CH_W = 3;
  localparam logic [1:0] MODE_EXT_CLK = 2'b11;
endpackage

// File: rtl/adc_fe_sync.sv
module adc_fe_sync #(
  parameter int         STAGES  = 2,
  parameter int         N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[b]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], in_i[b]};
    end
    assign lvl_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/adc_fe_seq.sv
module adc_fe_seq
  import adc_fe_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int TRACK_BIT = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_hi_i,
  input  logic  sclk_i,
  input  logic  din_i,
  output ctrl_t ctrl_o,
  output logic  track_o,
  output logic  busy_o,
  output logic  strb_o,
  output logic  load_o,
  output logic  shift_o,
  output logic  clr_o,
  output logic  fall_o
);
  localparam int LAST  = CTRL_W + DATA_W;
  localparam int CNT_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TRK = CNT_W'(TRACK_BIT);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(CTRL_W - 1);
  localparam logic [CNT_W-1:0] CNT_CW  = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LAST);

  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CTRL_W-2:0] shreg_q;
  ctrl_t             ctrl_q;
  logic              sclk_q, track_q, busy_q, strb_q;
  logic              rise, fall, ext;

  assign rise = sclk_i & ~sclk_q & ~cs_hi_i;
  assign fall = ~sclk_i & sclk_q & ~cs_hi_i;
  assign ext  = (ctrl_q.mode == MODE_EXT_CLK);

  always_comb begin
    load_o  = (st_q == ST_CTRL) && fall && (cnt_q == CNT_CW) && ext;
    shift_o = (st_q == ST_CONV) && fall && (cnt_q < CNT_END);
    clr_o   = cs_hi_i || ((st_q == ST_CONV) && fall && (cnt_q == CNT_END));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      cnt_q   <= '0;
      shreg_q <= '0;
      ctrl_q  <= '0;
      track_q <= 1'b0;
      busy_q  <= 1'b0;
      strb_q  <= 1'b0;
    end else if (cs_hi_i) begin
      st_q    <= ST_HUNT;
      cnt_q   <= '0;
      track_q <= 1'b0;
      busy_q  <= 1'b0;
      strb_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_HUNT: begin
          if (rise && din_i) begin
            st_q    <= ST_CTRL;
            cnt_q   <= CNT_ONE;
            shreg_q <= {{(CTRL_W-2){1'b0}}, 1'b1};
          end
        end
        ST_CTRL: begin
          if (rise) begin
            cnt_q   <= cnt_q + CNT_ONE;
            shreg_q <= {shreg_q[CTRL_W-3:0], din_i};
            if (cnt_q == CNT_PRE) ctrl_q <= ctrl_t'({shreg_q, din_i});
          end
          if (fall) begin
            if (cnt_q == CNT_TRK) track_q <= 1'b1;
            if (cnt_q == CNT_CW) begin
              track_q <= 1'b0;
              if (ext) begin
                st_q   <= ST_CONV;
                busy_q <= 1'b1;
                strb_q <= 1'b1;
              end else begin
                st_q <= ST_PARK;
              end
            end
          end
        end
        ST_CONV: begin
          if (fall) begin
            cnt_q <= cnt_q + CNT_ONE;
            if (cnt_q == CNT_CW) strb_q <= 1'b0;
            if (cnt_q == CNT_END) begin
              busy_q <= 1'b0;
              st_q   <= ST_HUNT;
              cnt_q  <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign track_o = track_q;
  assign busy_o  = busy_q;
  assign strb_o  = strb_q;
  assign fall_o  = fall;

  // R5: strobe only inside the conversion phase
  a_r5_strb_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_q |-> busy_q);
  // R4: track window and conversion phase never overlap
  a_r4_track_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(track_q && busy_q));
  // R10: chip select high returns to idle
  a_r10_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |=> (st_q == ST_HUNT) && !track_q && !busy_q && !strb_q);
  // R2: control register moves only after a rising serial edge
  a_r2_ctrl_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(rise));
  // R9: parked transfer stays quiet
  a_r9_park_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PARK) |-> !busy_q && !strb_q);
endmodule

// File: rtl/adc_fe_out.sv
module adc_fe_out #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              bipolar_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              shift_i,
  input  logic              clr_i,
  output logic              dout_o
);
  localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sr_q;
  logic              dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
    end else if (clr_i) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
    end else if (load_i) begin
      sr_q <= bipolar_i ? (sample_i ^ SIGN_FLIP) : sample_i;
    end else if (shift_i) begin
      dout_q <= sr_q[DATA_W-1];
      sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  assign dout_o = dout_q;

  // R7: shift register holds between load and shift events
  a_r7_sr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !shift_i && !clr_i |=> $stable(sr_q));
endmodule

// File: rtl/adc_fe_decode.sv
module adc_fe_decode
  import adc_fe_pkg::*;
(
  input  logic [2:0]      sel_i,
  input  logic            unipolar_i,
  input  logic            single_i,
  output logic [CH_W-1:0] ch_pos_o,
  output logic [CH_W-1:0] ch_neg_o,
  output logic            neg_com_o,
  output logic            bipolar_o
);
  always_comb begin
    ch_pos_o  = {sel_i[1:0], sel_i[2]};
    neg_com_o = single_i;
    ch_neg_o  = single_i ? '0 : (ch_pos_o ^ CH_W'(1));
    bipolar_o = ~unipolar_i;
  end
endmodule

// File: rtl/adc_serial_fe.sv
module adc_serial_fe
  import adc_fe_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int TRACK_BIT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              strb_o,
  output logic              track_o,
  output logic              busy_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CH_W-1:0]   ch_pos_o,
  output logic [CH_W-1:0]   ch_neg_o,
  output logic              neg_com_o,
  output logic              bipolar_o
);
  logic [2:0] pin_lvl;
  logic       cs_hi, sclk_s, din_s;
  logic       load, shift, clr, sclk_fall;
  ctrl_t      ctrl;

  adc_fe_sync #(.STAGES(SYNC_STAGES), .N(3), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({din_i, sclk_i, cs_ni}),
    .lvl_o (pin_lvl)
  );
  assign cs_hi  = pin_lvl[0];
  assign sclk_s = pin_lvl[1];
  assign din_s  = pin_lvl[2];

  adc_fe_seq #(.DATA_W(DATA_W), .TRACK_BIT(TRACK_BIT)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_hi_i(cs_hi),
    .sclk_i (sclk_s),
    .din_i  (din_s),
    .ctrl_o (ctrl),
    .track_o(track_o),
    .busy_o (busy_o),
    .strb_o (strb_o),
    .load_o (load),
    .shift_o(shift),
    .clr_o  (clr),
    .fall_o (sclk_fall)
  );

  adc_fe_decode u_dec (
    .sel_i     (ctrl.sel),
    .unipolar_i(ctrl.unipolar),
    .single_i  (ctrl.single),
    .ch_pos_o  (ch_pos_o),
    .ch_neg_o  (ch_neg_o),
    .neg_com_o (neg_com_o),
    .bipolar_o (bipolar_o)
  );

  adc_fe_out #(.DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .bipolar_i(bipolar_o),
    .sample_i (sample_i),
    .shift_i  (shift),
    .clr_i    (clr),
    .dout_o   (dout_o)
  );

  assign ctrl_o = ctrl;

  // R6: data out moves only after a falling serial edge or an abort
  a_r6_dout_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> $past(sclk_fall || cs_hi));
  // R5: strobe moves only after a falling serial edge or an abort
  a_r5_strb_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(strb_o) |-> $past(sclk_fall || cs_hi));
endmodule

// File: tb/adc_serial_fe_tb.sv
module adc_serial_fe_tb_top;
  localparam int HALF = 8;
  localparam int WD_LIMIT = 100000;
  localparam int NVEC = 6;
  // {ctrl byte, sample, leading zeros, result-phase fill}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h8F, 12'hABC, 3'd0, 1'b0},
    {8'hF7, 12'h000, 3'd3, 1'b0},
    {8'hA3, 12'hFFF, 3'd1, 1'b1},
    {8'hDB, 12'h801, 3'd5, 1'b0},
    {8'hFF, 12'h555, 3'd0, 1'b1},
    {8'hBF, 12'hFFF, 3'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] sample = '0;
  logic        dout, strb, track, busy, neg_com, bipolar;
  logic [7:0]  ctrl;
  logic [2:0]  ch_pos, ch_neg;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [24:0] s_dout, s_strb, s_track, s_busy;
  logic p_dout, p_strb, p_track, p_busy;

  always #2 clk = ~clk;

  adc_serial_fe dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .sample_i(sample), .dout_o(dout), .strb_o(strb), .track_o(track),
    .busy_o(busy), .ctrl_o(ctrl), .ch_pos_o(ch_pos), .ch_neg_o(ch_neg),
    .neg_com_o(neg_com), .bipolar_o(bipolar)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sclk_cycle(input logic d);
    din = d;
    repeat (HALF) @(negedge clk);
    p_dout = dout; p_strb = strb; p_track = track; p_busy = busy;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] cb, input logic [11:0] smp, input int nlead,
                           input logic fill, input int nbody, input logic keep);
    s_dout = '0; s_strb = '0; s_track = '0; s_busy = '0;
    sample = smp;
    if (cs_n) begin
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    for (int c = 1; c <= nlead + nbody; c++) begin
      int j;
      logic d;
      j = c - nlead;
      d = 1'b0;
      if (j >= 1 && j <= 8) d = cb[8-j];
      else if (j >= 9 && j <= 21) d = fill;
      if (j == 12) sample = ~smp;
      sclk_cycle(d);
      if (j >= 1) begin
        s_dout[j] = p_dout; s_strb[j] = p_strb; s_track[j] = p_track; s_busy[j] = p_busy;
      end
    end
    if (!keep) begin
      cs_n = 1'b1;
      repeat (4*HALF) @(negedge clk);
    end
  endtask

  task automatic check_frame(input string tag, input logic [7:0] cb, input logic [11:0] smp, input logic act);
    logic [11:0] res;
    logic [15:0] rx, rx_exp;
    logic [24:0] e_strb, e_track, e_busy;
    logic [2:0]  pos, neg;
    logic        ext;
    ext = act && (cb[1:0] == 2'b11);
    res = cb[3] ? smp : (smp ^ 12'h800);
    rx = '0;
    for (int j = 9; j <= 24; j++) rx = {rx[14:0], s_dout[j]};
    rx_exp = ext ? {1'b0, res, 3'b000} : 16'h0;
    e_strb = '0; e_track = '0; e_busy = '0;
    for (int j = 1; j <= 24; j++) begin
      e_track[j] = act && j >= 6 && j <= 8;
      e_strb[j]  = ext && j == 9;
      e_busy[j]  = ext && j >= 9 && j <= 21;
    end
    pos = {cb[5:4], cb[6]};
    neg = cb[2] ? 3'd0 : (pos ^ 3'd1);
    chk(ctrl == cb, {tag, " R2 ctrl byte"}, 32'(ctrl), 32'(cb));
    chk({ch_pos, ch_neg, neg_com, bipolar} == {pos, neg, cb[2], ~cb[3]},
        {tag, " R3 decode"}, 32'({ch_pos, ch_neg, neg_com, bipolar}), 32'({pos, neg, cb[2], ~cb[3]}));
    chk(rx == rx_exp, {tag, " R6 R7 R8 result word"}, 32'(rx), 32'(rx_exp));
    chk(s_track == e_track, {tag, " R4 track window"}, 32'(s_track), 32'(e_track));
    chk(s_busy == e_busy, {tag, " R4 busy window"}, 32'(s_busy), 32'(e_busy));
    chk(s_strb == e_strb, {tag, " R5 strobe"}, 32'(s_strb), 32'(e_strb));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk({dout, strb, track, busy} == 4'b0, "R12 reset flags", 32'({dout, strb, track, busy}), 32'h0);
    chk(ctrl == 8'h00, "R12 reset ctrl", 32'(ctrl), 32'h0);
    chk({ch_pos, ch_neg, neg_com, bipolar} == {3'd0, 3'd1, 1'b0, 1'b1}, "R12 reset decode",
        32'({ch_pos, ch_neg, neg_com, bipolar}), 32'({3'd0, 3'd1, 1'b0, 1'b1}));

    // R1: toggling with chip select high
    s_busy = '0;
    for (int k = 1; k <= 12; k++) begin
      sclk_cycle(1'b1);
      s_busy[k] = p_busy | p_track | p_strb | p_dout;
    end
    repeat (HALF) @(negedge clk);
    chk(ctrl == 8'h00, "R1 ctrl untouched with cs high", 32'(ctrl), 32'h0);
    chk(s_busy == '0, "R1 no activity with cs high", 32'(s_busy), 32'h0);

    // main table
    for (int v = 0; v < NVEC; v++) begin
      run_frame(VEC[v][23:16], VEC[v][15:4], int'(VEC[v][3:1]), VEC[v][0], 24, 1'b0);
      check_frame($sformatf("vec%0d", v), VEC[v][23:16], VEC[v][15:4], 1'b1);
    end

    // R9: non-external mode parks, later byte ignored until cs rises
    run_frame(8'h8D, 12'h3A5, 0, 1'b0, 24, 1'b1);
    check_frame("R9 park", 8'h8D, 12'h3A5, 1'b1);
    run_frame(8'hFF, 12'h3A5, 0, 1'b0, 24, 1'b0);
    check_frame("R9 ignored", 8'h8D, 12'h3A5, 1'b0);

    // R10: abort inside control byte
    run_frame(8'hF3, 12'h111, 0, 1'b0, 6, 1'b1);
    repeat (HALF) @(negedge clk);
    chk(track == 1'b1, "R4 track open before abort", 32'(track), 32'h1);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
    chk(track == 1'b0, "R10 track cleared", 32'(track), 32'h0);
    chk(ctrl == 8'h8D, "R10 ctrl keeps last full byte", 32'(ctrl), 32'h8D);

    // R10: abort inside result phase
    run_frame(8'h8F, 12'hFFF, 0, 1'b0, 14, 1'b1);
    repeat (HALF) @(negedge clk);
    chk(dout == 1'b1 && busy == 1'b1, "R6 shifting before abort", 32'({dout, busy}), 32'h3);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
    chk({dout, strb, busy, track} == 4'b0, "R10 outputs cleared", 32'({dout, strb, busy, track}), 32'h0);

    // R10 rearm, then R11 back-to-back without cs toggle
    run_frame(8'hA7, 12'h123, 2, 1'b1, 24, 1'b1);
    check_frame("R10 R11 first", 8'hA7, 12'h123, 1'b1);
    run_frame(8'hCF, 12'h3C5, 0, 1'b0, 24, 1'b0);
    check_frame("R11 second", 8'hCF, 12'h3C5, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule